// File: doc/BRIEF.md
# Multi-Mode Converter Sample Serializer

This block turns one converter sample per frame period into a serial bit stream on one or two output lanes. It also produces a frame marker that rises on the first bit of every frame and a pair of bit-clock edge flags for each bit slot. The block runs on a clock at the bit rate, so each lane moves one bit per clock cycle. The bit-clock flags show whether the external bit clock has a rising edge, a falling edge or both in that slot. That lets double-rate and single-rate capture be modelled without a faster clock.

Several configuration inputs select the framing. The word is either the bare sample width or padded with zeros above the sample to the wider width. Bits go out most-significant first or least-significant first. One lane or two can be used. With two lanes there are three ways of splitting the samples between them. The configuration and the sample are both taken only at a frame start, so the frame in flight is never disturbed.

Top module: `adc_lane_serializer`

## Requirements
- R1: While the reset input is low, both lanes, the frame marker and both edge flags are low. After release, the first frame begins so that its first bit is on the lanes in the third cycle after the release edge.
- R2: A frame lasts L cycles in one-lane mode and L/2 cycles in two-lane mode. L is 14 when the wide input is 0 and 16 when it is 1. In the 16-bit word, bits 15 and 14 are zero and bits 13..0 are the sample.
- R3: In one-lane mode, lane A sends word bit k in cycle k of the frame when the order input is 0 (least-significant first). When the order input is 1 it sends bit L-1-k.
- R4: With mapping code 0 (byte split) in two-lane mode, lane A carries word bits L-1..L/2 and lane B carries bits L/2-1..0. Each lane sends its bits in the selected order.
- R5: With mapping code 1 (bit split) in two-lane mode, lane A carries the odd word bits and lane B the even bits. With most-significant first they go out as L-1, L-3, ... and L-2, L-4, .... With least-significant first they go out as 1, 3, ... and 0, 2, ....
- R6: With mapping code 2 (word split) in two-lane mode, a frame lasts L/2 cycles. Each lane sends one whole word over two consecutive frames. Lane A takes the sample latched at the first frame after entering the mode and at every second frame after that. Lane B takes the samples latched at the frames in between. Lane B sends zeros until it has been given a word.
- R7: The frame marker is high for the first floor(F/2) cycles of each F-cycle frame, and its rising edge coincides with the first bit.
- R8: With the single-rate input at 0, exactly one edge flag is high in each slot, and rising and falling alternate from slot to slot. With it at 1, both flags are high in every slot.
- R9: The sample and all configuration inputs are latched only at a frame start. Changing them mid-frame has no effect on the rest of that frame.
- R10: In one-lane mode lane B stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit-rate clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| smp_i | input | SMP_W | Converter sample, taken at frame start |
| cfg_wide_i | input | 1 | 1: pad to PAD_W bits, 0: SMP_W bits |
| cfg_msb_i | input | 1 | 1: most-significant bit first |
| cfg_two_i | input | 1 | 1: two lanes, 0: one lane |
| cfg_map_i | input | 2 | Two-lane split: 0 byte, 1 bit, 2 word, 3 as byte |
| cfg_sdr_i | input | 1 | 1: single-rate bit clock, 0: double-rate |
| lane_a_o | output | 1 | Serial data, lane A |
| lane_b_o | output | 1 | Serial data, lane B |
| frame_o | output | 1 | Frame marker |
| bclk_rise_o | output | 1 | Bit clock has a rising edge in this slot |
| bclk_fall_o | output | 1 | Bit clock has a falling edge in this slot |

## Verification
The bench builds the block with its defaults, a 14-bit sample and a 16-bit padded word. That puts both word lengths within reach, including the odd 7-cycle two-lane frame, where the frame marker rounds down and the double-rate edge phase carries over between frames. A fixed sample with bits 13, 1 and 0 set places known bits at both ends of every lane stream, so each split and order gives a distinct pattern. Word-split mode is driven across three frames to expose the staggered hand-off between the lanes.

// File: rtl/adc_ser_pkg.sv
package adc_ser_pkg;

  typedef enum logic [1:0] {
    MAP_BYTE  = 2'd0,
    MAP_BIT   = 2'd1,
    MAP_WORD  = 2'd2,
    MAP_SPARE = 2'd3
  } lane_map_e;

  typedef struct packed {
    logic      wide;
    logic      msb_first;
    logic      two_lane;
    lane_map_e map;
    logic      sdr;
  } ser_cfg_t;

endpackage

// File: rtl/adc_ser_timing.sv
module adc_ser_timing
  import adc_ser_pkg::*;
#(
  parameter int SMP_W = 14,
  parameter int PAD_W = 16,
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  ser_cfg_t         cfg_d_i,
  output ser_cfg_t         cfg_q_o,
  output logic [CNT_W-1:0] cnt_q_o,
  output logic [CNT_W:0]   wlen_o,
  output logic [CNT_W:0]   flen_o,
  output logic             armed_q_o,
  output logic             par_q_o,
  output logic             ph_q_o,
  output logic             load_a_o,
  output logic             load_b_o
);

  localparam logic [CNT_W:0] NARROW_LEN = (CNT_W+1)'(SMP_W);
  localparam logic [CNT_W:0] WIDE_LEN   = (CNT_W+1)'(PAD_W);

  ser_cfg_t         cfg_q, cfg_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             armed_q, armed_n;
  logic             par_q, par_n;
  logic             ph_q, ph_n;
  logic             fstart, new_word, old_word;
  logic [CNT_W:0]   wlen, flen;

  // next-state logic: frame counter, configuration hold (R9), word parity (R6)
  always_comb begin
    wlen     = cfg_q.wide ? WIDE_LEN : NARROW_LEN;
    flen     = cfg_q.two_lane ? (wlen >> 1) : wlen;
    fstart   = !armed_q || ({1'b0, cnt_q} == (flen - 1'b1));
    new_word = cfg_d_i.two_lane && (cfg_d_i.map == MAP_WORD);
    old_word = armed_q && cfg_q.two_lane && (cfg_q.map == MAP_WORD);

    armed_n = 1'b1;
    cnt_n   = fstart ? '0 : cnt_q + 1'b1;
    cfg_n   = fstart ? cfg_d_i : cfg_q;
    par_n   = par_q;
    if (fstart) par_n = (new_word && old_word) ? !par_q : 1'b0;
    ph_n    = armed_q ? !ph_q : 1'b0;

    load_a_o = fstart && !(new_word && par_n);
    load_b_o = fstart && new_word && par_n;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q   <= '0;
      cnt_q   <= '0;
      armed_q <= 1'b0;
      par_q   <= 1'b0;
      ph_q    <= 1'b0;
    end else begin
      cfg_q   <= cfg_n;
      cnt_q   <= cnt_n;
      armed_q <= armed_n;
      par_q   <= par_n;
      ph_q    <= ph_n;
    end
  end

  assign cfg_q_o   = cfg_q;
  assign cnt_q_o   = cnt_q;
  assign wlen_o    = wlen;
  assign flen_o    = flen;
  assign armed_q_o = armed_q;
  assign par_q_o   = par_q;
  assign ph_q_o    = ph_q;

endmodule

// File: rtl/adc_ser_store.sv
module adc_ser_store #(
  parameter int SMP_W = 14,
  parameter int PAD_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_a_i,
  input  logic             load_b_i,
  input  logic [SMP_W-1:0] smp_i,
  output logic [PAD_W-1:0] word_a_o,
  output logic [PAD_W-1:0] word_b_o
);

  logic [PAD_W-1:0] padded;
  logic [PAD_W-1:0] word_a_q, word_a_n;
  logic [PAD_W-1:0] word_b_q, word_b_n;

  // zero padding above the sample (R2); loads only at frame start (R9)
  always_comb begin
    padded   = PAD_W'(smp_i);
    word_a_n = load_a_i ? padded : word_a_q;
    word_b_n = load_b_i ? padded : word_b_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_a_q <= '0;
      word_b_q <= '0;
    end else begin
      word_a_q <= word_a_n;
      word_b_q <= word_b_n;
    end
  end

  assign word_a_o = word_a_q;
  assign word_b_o = word_b_q;

endmodule

// File: rtl/adc_ser_pick.sv
module adc_ser_pick
  import adc_ser_pkg::*;
#(
  parameter int PAD_W = 16,
  parameter int CNT_W = 4
) (
  input  ser_cfg_t         cfg_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W:0]   wlen_i,
  input  logic             armed_i,
  input  logic             par_i,
  input  logic [PAD_W-1:0] word_a_i,
  input  logic [PAD_W-1:0] word_b_i,
  output logic [1:0]       lane_o
);

  // lane 0 is A, lane 1 is B; bit selection per R3..R6
  for (genvar g = 0; g < 2; g++) begin : g_lane
    int               idx;
    int               len;
    int               half;
    int               p;
    int               pos;
    logic             upper;
    logic             active;
    logic [PAD_W-1:0] src;
    logic [PAD_W-1:0] shifted;
    logic             bit_v;

    always_comb begin
      len    = int'(wlen_i);
      half   = len / 2;
      p      = int'(cnt_i);
      pos    = p;
      upper  = 1'b0;
      src    = word_a_i;
      active = armed_i && ((g == 0) || cfg_i.two_lane);
      if (!cfg_i.two_lane) begin
        idx = cfg_i.msb_first ? (len - 1 - p) : p;
      end else begin
        case (cfg_i.map)
          MAP_BIT: begin
            idx = cfg_i.msb_first ? (len - 1 - g - 2 * p) : (2 * p + 1 - g);
          end
          MAP_WORD: begin
            src   = (g == 0) ? word_a_i : word_b_i;
            upper = (g == 0) ? par_i : !par_i;
            pos   = upper ? (half + p) : p;
            idx   = cfg_i.msb_first ? (len - 1 - pos) : pos;
          end
          default: begin
            if (cfg_i.msb_first) idx = ((g == 0) ? len : half) - 1 - p;
            else                 idx = ((g == 0) ? half : 0) + p;
          end
        endcase
      end
      shifted = src >> idx;
      bit_v   = active && (idx >= 0) && (idx < PAD_W) && shifted[0];
    end

    assign lane_o[g] = bit_v;
  end

endmodule

// File: rtl/adc_lane_serializer.sv
module adc_lane_serializer
  import adc_ser_pkg::*;
#(
  parameter int SMP_W = 14,
  parameter int PAD_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SMP_W-1:0] smp_i,
  input  logic             cfg_wide_i,
  input  logic             cfg_msb_i,
  input  logic             cfg_two_i,
  input  logic [1:0]       cfg_map_i,
  input  logic             cfg_sdr_i,
  output logic             lane_a_o,
  output logic             lane_b_o,
  output logic             frame_o,
  output logic             bclk_rise_o,
  output logic             bclk_fall_o
);

  localparam int CNT_W = $clog2(PAD_W);

  logic [1:0]       rst_sync_q;
  logic             rst_n;
  ser_cfg_t         cfg_d, cfg_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   wlen, flen;
  logic             armed_q, par_q, ph_q, load_a, load_b;
  logic [PAD_W-1:0] word_a, word_b;
  logic [1:0]       lanes;

  // reset asserted at once, released through two stages (R1)
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= '0;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  always_comb begin
    cfg_d.wide      = cfg_wide_i;
    cfg_d.msb_first = cfg_msb_i;
    cfg_d.two_lane  = cfg_two_i;
    cfg_d.map       = lane_map_e'(cfg_map_i);
    cfg_d.sdr       = cfg_sdr_i;
  end

  adc_ser_timing #(.SMP_W(SMP_W), .PAD_W(PAD_W), .CNT_W(CNT_W)) u_timing (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .cfg_d_i  (cfg_d),
    .cfg_q_o  (cfg_q),
    .cnt_q_o  (cnt_q),
    .wlen_o   (wlen),
    .flen_o   (flen),
    .armed_q_o(armed_q),
    .par_q_o  (par_q),
    .ph_q_o   (ph_q),
    .load_a_o (load_a),
    .load_b_o (load_b)
  );

  adc_ser_store #(.SMP_W(SMP_W), .PAD_W(PAD_W)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .load_a_i(load_a),
    .load_b_i(load_b),
    .smp_i   (smp_i),
    .word_a_o(word_a),
    .word_b_o(word_b)
  );

  adc_ser_pick #(.PAD_W(PAD_W), .CNT_W(CNT_W)) u_pick (
    .cfg_i   (cfg_q),
    .cnt_i   (cnt_q),
    .wlen_i  (wlen),
    .armed_i (armed_q),
    .par_i   (par_q),
    .word_a_i(word_a),
    .word_b_i(word_b),
    .lane_o  (lanes)
  );

  // frame marker (R7) and bit-clock edge flags (R8)
  assign lane_a_o    = lanes[0];
  assign lane_b_o    = lanes[1];
  assign frame_o     = armed_q && ({1'b0, cnt_q} < (flen >> 1));
  assign bclk_rise_o = armed_q && (cfg_q.sdr || !ph_q);
  assign bclk_fall_o = armed_q && (cfg_q.sdr || ph_q);

endmodule

// File: rtl/adc_lane_serializer_chk.sv
module adc_lane_serializer_chk
  import adc_ser_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             armed_i,
  input ser_cfg_t         cfg_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic [CNT_W:0]   flen_i,
  input logic             lane_a_i,
  input logic             lane_b_i,
  input logic             frame_i,
  input logic             rise_i,
  input logic             fall_i
);

  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed_i |-> !(lane_a_i || lane_b_i || frame_i || rise_i || fall_i));

  a_r2_count_in_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_i |-> ({1'b0, cnt_i} < flen_i));

  a_r7_marker_on_first_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(frame_i) |-> (cnt_i == '0));

  a_r8_edge_each_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_i |-> (rise_i || fall_i));

  a_r8_ddr_alternate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_i && !cfg_i.sdr && $past(armed_i) && !$past(cfg_i.sdr)) |-> (rise_i != $past(rise_i)));

  a_r9_cfg_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_i && (cnt_i != '0)) |-> $stable(cfg_i));

  a_r10_lane_b_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_i && !cfg_i.two_lane) |-> !lane_b_i);

endmodule

bind adc_lane_serializer adc_lane_serializer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_n),
  .armed_i (armed_q),
  .cfg_i   (cfg_q),
  .cnt_i   (cnt_q),
  .flen_i  (flen),
  .lane_a_i(lane_a_o),
  .lane_b_i(lane_b_o),
  .frame_i (frame_o),
  .rise_i  (bclk_rise_o),
  .fall_i  (bclk_fall_o)
);

// File: tb/adc_lane_serializer_test.sv
module adc_lane_serializer_test;

  typedef struct packed {
    logic        two;
    logic [1:0]  map;
    logic        wide;
    logic        msb;
    logic        sdr;
    logic [7:0]  flen;
    logic [15:0] ea;
    logic [15:0] eb;
  } vec_t;

  // sample 14'h2003 throughout; ea/eb bit k = lane value in cycle k
  localparam vec_t TBL [10] = '{
    '{1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 8'd14, 16'h2003, 16'h0000},
    '{1'b0, 2'd0, 1'b0, 1'b1, 1'b1, 8'd14, 16'h3001, 16'h0000},
    '{1'b0, 2'd0, 1'b1, 1'b0, 1'b1, 8'd16, 16'h2003, 16'h0000},
    '{1'b0, 2'd0, 1'b1, 1'b1, 1'b0, 8'd16, 16'hC004, 16'h0000},
    '{1'b1, 2'd0, 1'b1, 1'b1, 1'b0, 8'd8,  16'h0004, 16'h00C0},
    '{1'b1, 2'd0, 1'b1, 1'b0, 1'b1, 8'd8,  16'h0020, 16'h0003},
    '{1'b1, 2'd0, 1'b0, 1'b1, 1'b0, 8'd7,  16'h0001, 16'h0060},
    '{1'b1, 2'd1, 1'b1, 1'b0, 1'b0, 8'd8,  16'h0041, 16'h0001},
    '{1'b1, 2'd1, 1'b1, 1'b1, 1'b1, 8'd8,  16'h0082, 16'h0080},
    '{1'b1, 2'd1, 1'b0, 1'b1, 1'b0, 8'd7,  16'h0041, 16'h0040}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic [13:0] smp;
  logic        c_wide, c_msb, c_two, c_sdr;
  logic [1:0]  c_map;
  logic        lane_a, lane_b, frame, rise, fall;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  adc_lane_serializer uut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .smp_i      (smp),
    .cfg_wide_i (c_wide),
    .cfg_msb_i  (c_msb),
    .cfg_two_i  (c_two),
    .cfg_map_i  (c_map),
    .cfg_sdr_i  (c_sdr),
    .lane_a_o   (lane_a),
    .lane_b_o   (lane_b),
    .frame_o    (frame),
    .bclk_rise_o(rise),
    .bclk_fall_o(fall)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic check_quiet(input string tag);
    check(!(lane_a || lane_b || frame || rise || fall), tag,
          {lane_a, lane_b, frame, rise, fall}, 0);
  endtask

  task automatic wait_rise(output bit ok, output int waited);
    bit prev;
    prev   = frame;
    ok     = 1'b0;
    waited = 0;
    for (int i = 1; i <= 64; i++) begin
      @(negedge clk);
      if (frame && !prev) begin
        ok     = 1'b1;
        waited = i;
        break;
      end
      prev = frame;
    end
  endtask

  // called at the negedge showing cycle 0 of a frame; returns at cycle 0 of the next
  task automatic cap_frame(input int n, input bit sdr_exp, input int poke_at,
                           output logic [31:0] a, output logic [31:0] b,
                           output int hi, output bit clk_ok, output int len);
    bit prevr;
    bit prevf;
    a = '0; b = '0; hi = 0; clk_ok = 1'b1; len = 0; prevr = 1'b0; prevf = 1'b0;
    for (int k = 0; k < n; k++) begin
      if (k > 0) @(negedge clk);
      a[k] = lane_a;
      b[k] = lane_b;
      if (frame) hi++;
      if (sdr_exp) clk_ok &= rise && fall;
      else         clk_ok &= (fall == !rise) && ((k == 0) || (rise != prevr));
      prevr = rise;
      prevf = frame;
      if (k == poke_at) begin
        smp   = 14'h0001;
        c_msb = ~c_msb;
      end
    end
    for (int i = 1; i <= 40; i++) begin
      @(negedge clk);
      if (frame && !prevf) begin
        len = n - 1 + i;
        break;
      end
      prevf = frame;
    end
  endtask

  task automatic apply(input vec_t v);
    c_two  = v.two;
    c_map  = v.map;
    c_wide = v.wide;
    c_msb  = v.msb;
    c_sdr  = v.sdr;
    smp    = 14'h2003;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R1 watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    bit ok;
    int waited, hi, len;
    bit clk_ok;
    logic [31:0] a, b;
    string tag;

    rst_n = 1'b0;
    apply(TBL[0]);
    repeat (3) @(negedge clk);
    check_quiet("R1 outputs low in reset");

    rst_n = 1'b1;
    wait_rise(ok, waited);
    check(ok && waited == 3, "R1 first frame after release", waited, 3);

    // table walk: cfg applied in cycle 0 of a frame takes effect one frame later
    for (int i = 0; i < 10; i++) begin
      apply(TBL[i]);
      wait_rise(ok, waited);
      check(ok, "R7 frame marker rises", ok, 1);
      cap_frame(int'(TBL[i].flen), TBL[i].sdr, -1, a, b, hi, clk_ok, len);
      if (!TBL[i].two)          tag = "R3 one-lane order";
      else if (TBL[i].map == 0) tag = "R4 byte split";
      else                      tag = "R5 bit split";
      check(a[15:0] == TBL[i].ea, {tag, " lane A"}, a, TBL[i].ea);
      check(b[15:0] == TBL[i].eb, TBL[i].two ? {tag, " lane B"} : "R10 lane B idle",
            b, TBL[i].eb);
      check(len == int'(TBL[i].flen), "R2 frame length", len, TBL[i].flen);
      check(hi == int'(TBL[i].flen) / 2, "R7 marker high cycles", hi, TBL[i].flen / 2);
      check(clk_ok, "R8 bit clock edges", clk_ok, 1);
    end

    // R9: sample and order changed in cycle 3 do not touch the running frame
    apply(TBL[3]);
    wait_rise(ok, waited);
    cap_frame(16, 1'b0, 3, a, b, hi, clk_ok, len);
    check(a[15:0] == 16'hC004, "R9 running frame keeps sample", a, 16'hC004);
    check(len == 16, "R9 running frame keeps length", len, 16);
    cap_frame(16, 1'b0, -1, a, b, hi, clk_ok, len);
    check(a[15:0] == 16'h0001, "R9 next frame takes new inputs", a, 16'h0001);

    // R6: word split, samples 2003, 0001, 2000 over three 8-cycle frames
    c_two = 1'b1; c_map = 2'd2; c_wide = 1'b1; c_msb = 1'b1; c_sdr = 1'b0;
    smp = 14'h2003;
    wait_rise(ok, waited);
    a = '0; b = '0;
    for (int k = 0; k < 24; k++) begin
      if (k > 0) @(negedge clk);
      a[k] = lane_a;
      b[k] = lane_b;
      if (k == 0) smp = 14'h0001;
      if (k == 8) smp = 14'h2000;
      if (k == 0 || k == 8 || k == 16)
        check(frame, "R6 frame every 8 cycles", frame, 1);
    end
    check(a[23:0] == 24'h04C004, "R6 word split lane A", a, 24'h04C004);
    check(b[23:0] == 24'h800000, "R6 word split lane B", b, 24'h800000);

    // R1: mid-run reset silences outputs at once and restarts framing
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check_quiet("R1 async reset clears outputs");
    @(negedge clk);
    check_quiet("R1 outputs held low");
    rst_n = 1'b1;
    wait_rise(ok, waited);
    check(ok && waited == 3, "R1 restart after second release", waited, 3);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule